// File: doc/BRIEF.md
# Buffered Compare Channel for a 16-bit Timer

This block is a single compare channel that sits beside a 16-bit up/down timer counter. On every timer tick it compares the counter value against its active compare register. When the two are equal it raises a match strobe. One timer tick later it latches a sticky event flag, and the flag drives an interrupt request when the channel's interrupt is enabled.

A CPU-side write port loads the compare value. In PWM modes the write is staged in a buffer. The buffer is copied into the active register only at the update point the mode selects, either the TOP strobe or the BOTTOM strobe, so that a period never uses a half-changed threshold. In the non-PWM modes the write lands in the active register at once. When the CPU writes the counter, the comparator is blanked for the next timer tick, even if that tick comes many cycles later. The readback port returns whichever register the CPU is currently addressing.

Top module: `tmr_cmp_chan`

## Requirements
- R1: `match` is 1 during a cycle with `tick`=1 in which `cnt_val` equals the active compare value and no blanking is pending. Otherwise `match` is 0, including every cycle with `tick`=0.
- R2: A match sets `flag` at the clock edge of the next cycle with `tick`=1, never at the edge of the matching cycle itself.
- R3: `irq` is 1 exactly when `flag` is 1 and `int_en` is 1.
- R4: `flag` clears at the edge of a cycle with `flag_clr`=1 or `int_ack`=1. If a flag set falls on the same edge, the set wins.
- R5: With `pwm_mode`=1, a `cmp_wr` stores `cmp_wdata` into the buffer only. `cmp_rdata` then returns the buffer, and the active value is unchanged until an update point.
- R6: In PWM mode the update point is a tick with `at_top`=1 when `load_at_top`=1, and a tick with `at_bottom`=1 when `load_at_top`=0. The strobe that is not selected never loads the active value.
- R7: With `pwm_mode`=0, a `cmp_wr` writes the active value directly, which is visible on the next cycle. `cmp_rdata` returns the active value, and TOP and BOTTOM strobes never load the buffer into it.
- R8: A cycle with `cnt_wr`=1 blocks any match on the next tick that follows it, however many tick-free cycles lie between. A tick in the same cycle as the write is not blocked.
- R9: A synchronous active-high `rst` clears the active value, the buffer, the flag, the pending match and the blanking, so `match`, `flag`, `irq` and `cmp_rdata` read 0 in either mode.
- R10: Without a tick, a pending match does not set `flag`, and the compare registers do not load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle timer clock enable |
| cnt_val | input | 16 | Current counter value |
| at_top | input | 1 | Counter is at TOP on this tick |
| at_bottom | input | 1 | Counter is at BOTTOM on this tick |
| pwm_mode | input | 1 | 1 selects buffered (PWM) operation |
| load_at_top | input | 1 | Update point: 1 = TOP, 0 = BOTTOM |
| cnt_wr | input | 1 | CPU wrote the counter this cycle |
| flag_clr | input | 1 | Software write-one clear of the flag |
| int_ack | input | 1 | Interrupt serviced |
| int_en | input | 1 | Channel interrupt enable |
| cmp_wr | input | 1 | CPU compare-value write strobe |
| cmp_wdata | input | 16 | CPU compare-value write data |
| cmp_rdata | output | 16 | Buffer in PWM mode, active value otherwise |
| match | output | 1 | Comparator match strobe |
| flag | output | 1 | Sticky compare event flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the one where timing facts interact. The flag must come from a match that was pending before a blanked tick. At the same time, a counter write must land on a cycle with a tick, or must be followed by tick-free cycles while the timer is stopped. The vector table reaches this by placing a counter write between an earlier match and the next tick. It then holds `tick` low for several cycles, so a single tick has to set the flag from the old match while blanking the new equality. Set-versus-clear collisions and an update strobe of the wrong kind are driven in the same way, as cycles placed so that only the correct priority or selection gives the expected readback.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    localparam int unsigned CMP_W = 16;

    typedef enum logic {
        UPD_BOTTOM = 1'b0,
        UPD_TOP    = 1'b1
    } upd_pt_e;

    typedef struct packed {
        logic    pwm;
        upd_pt_e upd;
    } cmp_mode_t;

    typedef struct packed {
        logic tick;
        logic top;
        logic bot;
    } tmr_evt_t;

    // Buffer-to-active transfer fires only on a tick, in PWM mode, at the chosen extreme.
    function automatic logic load_point(input cmp_mode_t m, input tmr_evt_t e);
        logic at_pt;
        at_pt = (m.upd == UPD_TOP) ? e.top : e.bot;
        return e.tick && m.pwm && at_pt;
    endfunction

endpackage

// File: rtl/tmr_cmp_regs.sv
module tmr_cmp_regs
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned W = CMP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cmp_mode_t    mode,
    input  tmr_evt_t     evt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] active,
    output logic [W-1:0] rdata
);

    logic [W-1:0] buf_q;
    logic [W-1:0] act_q;
    logic         load_ev;

    assign load_ev = load_point(mode, evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (wr && mode.pwm) begin
                buf_q <= wdata;
            end
            if (wr && !mode.pwm) begin
                act_q <= wdata;
            end else if (load_ev) begin
                act_q <= buf_q;
            end
        end
    end

    assign active = act_q;
    assign rdata  = mode.pwm ? buf_q : act_q;

    // R5 / R10: in PWM mode nothing moves the active value without a tick
    a_r5_pwm_hold: assert property (@(posedge clk) disable iff (rst)
        (mode.pwm && !evt.tick) |=> $stable(act_q));

    // R7: a direct write is visible on the next cycle
    a_r7_direct_write: assert property (@(posedge clk) disable iff (rst)
        (wr && !mode.pwm) |=> (act_q == $past(wdata)));

endmodule

// File: rtl/tmr_cmp_detect.sv
module tmr_cmp_detect
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned W = CMP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] active,
    input  logic         cnt_wr,
    output logic         match,
    output logic         set_req
);

    logic blank_q;
    logic pend_q;

    assign match   = tick && !blank_q && (cnt_val == active);
    assign set_req = tick && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (cnt_wr) begin
                blank_q <= 1'b1;
            end else if (tick) begin
                blank_q <= 1'b0;
            end
            if (tick) begin
                pend_q <= match;
            end
        end
    end

    // R8: the cycle after a counter write never reports a match
    a_r8_blank_next: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !match);

endmodule

// File: rtl/tmr_cmp_flag.sv
module tmr_cmp_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic sw_clr,
    input  logic ack,
    input  logic int_en,
    output logic flag,
    output logic irq
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_req) begin
            flag_q <= 1'b1;
        end else if (sw_clr || ack) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q && int_en;

    // R4: the set wins over a clear on the same edge
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_req |=> flag_q);

    // R4: a clear without a set empties the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        (!set_req && (sw_clr || ack)) |=> !flag_q);

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_cmp_pkg::*;
#(
    parameter int unsigned W = CMP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt_val,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic         pwm_mode,
    input  logic         load_at_top,
    input  logic         cnt_wr,
    input  logic         flag_clr,
    input  logic         int_ack,
    input  logic         int_en,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_rdata,
    output logic         match,
    output logic         flag,
    output logic         irq
);

    cmp_mode_t    mode;
    tmr_evt_t     evt;
    logic [W-1:0] active;
    logic         set_req;

    assign mode.pwm = pwm_mode;
    assign mode.upd = load_at_top ? UPD_TOP : UPD_BOTTOM;
    assign evt.tick = tick;
    assign evt.top  = at_top;
    assign evt.bot  = at_bottom;

    tmr_cmp_regs #(.W(W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .evt    (evt),
        .wr     (cmp_wr),
        .wdata  (cmp_wdata),
        .active (active),
        .rdata  (cmp_rdata)
    );

    tmr_cmp_detect #(.W(W)) u_detect (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt_val (cnt_val),
        .active  (active),
        .cnt_wr  (cnt_wr),
        .match   (match),
        .set_req (set_req)
    );

    tmr_cmp_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (set_req),
        .sw_clr  (flag_clr),
        .ack     (int_ack),
        .int_en  (int_en),
        .flag    (flag),
        .irq     (irq)
    );

    // R2 / R10: the flag only rises at the edge of a tick cycle
    a_r2_flag_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick));

    // R2: a match never sets the flag on its own edge unless an older match was pending
    a_r2_no_same_edge: assert property (@(posedge clk) disable iff (rst)
        (match && !set_req && (flag_clr || int_ack)) |=> !flag);

    // R9: one reset edge leaves the flag and request low
    a_r9_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!flag && !irq));

endmodule

// File: tb/tb_tmr_cmp_chan.sv
module tb_tmr_cmp_chan;

    typedef struct packed {
        logic        tick;
        logic [15:0] cnt;
        logic        top;
        logic        bot;
        logic        pwm;
        logic        seltop;
        logic        cwr;
        logic        clr;
        logic        ack;
        logic        ien;
        logic        wr;
        logic [15:0] wdata;
        logic        em;
        logic        ef;
        logic        ei;
        logic [15:0] erd;
    } vec_t;

    localparam int NV = 25;
    //                  tick cnt      top  bot  pwm  stop cwr  clr  ack  ien  wr   wdata    em   ef   ei   erd
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0010,1'b0,1'b0,1'b0,16'h0010}, // R7 direct write
        '{1'b1, 16'h0010, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0010}, // R1 match, R2 flag not yet
        '{1'b1, 16'h0011, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b1,1'b1,16'h0010}, // R2 flag next tick, R3
        '{1'b0, 16'h0011, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0010}, // R4 ack clears
        '{1'b0, 16'h0011, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0020,1'b0,1'b0,1'b0,16'h0020}, // R5 buffered write
        '{1'b1, 16'h0020, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0020}, // R5 R6 bottom ignored
        '{1'b1, 16'h0010, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0020}, // R6 old value, load at TOP
        '{1'b1, 16'h0020, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0020}, // R6 new value, R3 disabled
        '{1'b1, 16'h0021, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,16'h0020}, // R4 set wins
        '{1'b0, 16'h0021, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0020}, // R4 software clear
        '{1'b0, 16'h0021, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0030,1'b0,1'b0,1'b0,16'h0030}, // R5
        '{1'b1, 16'h0005, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0030}, // R6 top ignored
        '{1'b1, 16'h0020, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0030}, // R6 load at BOTTOM
        '{1'b0, 16'h0020, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0030}, // R10 pending, no tick
        '{1'b0, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0030}, // R8 counter write
        '{1'b0, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0030}, // R8 stopped timer
        '{1'b1, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b1,1'b1,16'h0030}, // R8 blanked, R2 old pend
        '{1'b1, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0030}, // R1 after blank, R4 ack
        '{1'b1, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0030}, // R8 same-cycle not blanked
        '{1'b1, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,16'h0030}, // R8 blanked tick
        '{1'b1, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0030}, // R1 R4
        '{1'b0, 16'h0030, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,16'h0040,1'b0,1'b0,1'b0,16'h0040}, // R7 buffer untouched
        '{1'b1, 16'h0000, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,16'h0040}, // R7 strobes ignored
        '{1'b0, 16'h0000, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0030}, // R5 buffer kept
        '{1'b0, 16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,16'h0040}  // R7 active kept
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        tick, at_top, at_bottom, pwm_mode, load_at_top;
    logic        cnt_wr, flag_clr, int_ack, int_en, cmp_wr;
    logic [15:0] cnt_val, cmp_wdata, cmp_rdata;
    logic        match, flag, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tmr_cmp_chan dut (
        .clk(clk), .rst(rst), .tick(tick), .cnt_val(cnt_val),
        .at_top(at_top), .at_bottom(at_bottom), .pwm_mode(pwm_mode),
        .load_at_top(load_at_top), .cnt_wr(cnt_wr), .flag_clr(flag_clr),
        .int_ack(int_ack), .int_en(int_en), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata), .match(match),
        .flag(flag), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        tick = 0; cnt_val = 0; at_top = 0; at_bottom = 0; pwm_mode = 0;
        load_at_top = 0; cnt_wr = 0; flag_clr = 0; int_ack = 0; int_en = 0;
        cmp_wr = 0; cmp_wdata = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 state after reset, both read views
        chk("R9", "match", {15'd0, match}, 16'd0);
        chk("R9", "flag",  {15'd0, flag},  16'd0);
        chk("R9", "irq",   {15'd0, irq},   16'd0);
        chk("R9", "rdata active", cmp_rdata, 16'h0000);
        pwm_mode = 1'b1;
        #1 chk("R9", "rdata buffer", cmp_rdata, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            tick = VECS[i].tick; cnt_val = VECS[i].cnt;
            at_top = VECS[i].top; at_bottom = VECS[i].bot;
            pwm_mode = VECS[i].pwm; load_at_top = VECS[i].seltop;
            cnt_wr = VECS[i].cwr; flag_clr = VECS[i].clr; int_ack = VECS[i].ack;
            int_en = VECS[i].ien; cmp_wr = VECS[i].wr; cmp_wdata = VECS[i].wdata;
            #1 chk("R1 R8", $sformatf("match v%0d", i), {15'd0, match}, {15'd0, VECS[i].em});
            @(posedge clk);
            #1;
            chk("R2 R4 R10", $sformatf("flag v%0d", i), {15'd0, flag}, {15'd0, VECS[i].ef});
            chk("R3", $sformatf("irq v%0d", i), {15'd0, irq}, {15'd0, VECS[i].ei});
            chk("R5 R6 R7", $sformatf("rdata v%0d", i), cmp_rdata, VECS[i].erd);
        end

        // R9: reset in mid-run wipes both registers
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "rdata active mid-run", cmp_rdata, 16'h0000);
        pwm_mode = 1'b1;
        #1 chk("R9", "rdata buffer mid-run", cmp_rdata, 16'h0000);

        // R1 / R2 / R3 at the counter's upper bound
        @(negedge clk);
        idle();
        cmp_wr = 1'b1; cmp_wdata = 16'hFFFF;
        @(negedge clk);
        idle();
        tick = 1'b1; cnt_val = 16'hFFFF; int_en = 1'b1;
        #1 chk("R1", "match at FFFF", {15'd0, match}, 16'd1);
        @(negedge clk);
        cnt_val = 16'h0000;
        #1 chk("R1", "no match after wrap", {15'd0, match}, 16'd0);
        chk("R2", "flag before set tick", {15'd0, flag}, 16'd0);
        @(negedge clk);
        chk("R2", "flag after wrap tick", {15'd0, flag}, 16'd1);
        chk("R3", "irq at FFFF event", {15'd0, irq}, 16'd1);

        done = 1'b1;
        finish_run();
    end

endmodule